// File: doc/BRIEF.md
# Parallel printer port controller

This block is a register-mapped 8-bit parallel port that sits on a simple processor read/write bus. It serves either as a general parallel I/O port or as a printer port. The eight data lines switch direction together under one control bit. Two active-low control outputs and five status inputs sit beside the data lines. In printer use the control outputs are the strobe and the input-prime line, and the status inputs carry acknowledge, fault, busy, select and paper error.

Each status input passes through a two-flop synchronizer. Each one has its own interrupt condition, chosen from four: high level, low level, falling edge or rising edge. Each also has its own enable bit and its own pending bit. A single interrupt output combines all the enabled pending bits. In auto-strobe mode, a write to the data register starts a strobe sequence. The data is first given a fixed setup delay. The strobe then goes low for a programmable number of cycles and returns high.

Top module: `lpt_port`

## Requirements
- R1: After reset, pd_oe=0, strobe_n=1, prime_n=1 and irq=0. The length register (address 2) reads 8'h04. All other registers read 0.
- R2: Control register (address 1) bit 0 sets the direction. At 1, pd_oe=1 and pd_out carries the data latch, which is written at address 0. At 0, pd_oe=0. The bit drives all eight lines at once.
- R3: A read of address 0 returns the data latch when bit 0 of the control register is 1. Otherwise it returns pd_in as seen through a two-flop synchronizer, so the value appears two clock edges after the pin changes.
- R4: A read of address 5 returns the synchronized status levels in bits [4:0]. A change on st_in appears there two clock edges later.
- R5: Each status input i has a 2-bit condition field: 00 high level, 01 low level, 10 falling edge, 11 rising edge. For i=0..3 the field sits at address 6 bits [2i+1:2i]. For i=4 it sits at address 7 bits [1:0]. Both registers read back what was written.
- R6: In an edge mode, the pending bit (address 4, bit i) is set by a synchronized edge of the chosen polarity. It stays set until software writes 1 to that bit at address 4. If a new edge arrives in the same cycle as the clear, the new edge wins and the bit stays 1.
- R7: In a level mode, the pending bit follows the chosen level one edge after the synchronized value, but only while enable bit i (address 3) is 1. While the enable is 0 the bit reads 0.
- R8: irq is 1 exactly when some pending bit at address 4 has its enable bit at address 3 set.
- R9: Auto-strobe is control bit 1. With it set, a write to address 0 starts a sequence. strobe_n stays high for the 2 edges after the write edge. It then goes low for N cycles, where N is the value at address 2, and a value of 0 counts as 1. After that it returns high.
- R10: A write to address 0 during the setup delay or the pulse restarts the sequence from the setup delay, using the new data.
- R11: Control bit 3 drives prime_n low whenever it is 1. Control bit 2 drives strobe_n low while auto-strobe is off. Bit 2 has no effect on strobe_n while auto-strobe is on.
- R12: Writing the control register with auto-strobe cleared ends any pending or active sequence at once. strobe_n then follows control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pd_in | input | 8 | Data pins as received |
| pd_out | output | 8 | Data pins as driven |
| pd_oe | output | 1 | Output enable for all eight data pins |
| st_in | input | 5 | Status pins: ack, fault_n, busy, select, paper error |
| strobe_n | output | 1 | Strobe control pin, active low |
| prime_n | output | 1 | Input-prime control pin, active low |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land on the same clock edge: an edge-mode status event and a software write-one-to-clear of that same pending bit. The bench provokes this by changing a status pin and timing the clear so that it is sampled on the exact edge at which the synchronized edge is detected. The reference model then expects the bit to stay set. A second overlap is a data write that arrives during a running strobe sequence, or a control write that clears auto-strobe during the pulse. For both, the behavioural model predicts strobe_n on every cycle, and each cycle is compared against it.

// File: rtl/lpt_port.sv
module lpt_port #(
  parameter int LEN_W     = 8,
  parameter int LEN_RST   = 4,
  parameter int SETUP_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pd_in,
  output logic [7:0] pd_out,
  output logic       pd_oe,
  input  logic [4:0] st_in,
  output logic       strobe_n,
  output logic       prime_n,
  output logic       irq
);
  localparam int NST = 5;
  localparam logic [LEN_W-1:0] SETUP_LAST = LEN_W'(SETUP_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_PULSE} stb_t;

  logic [7:0]       dout, pd_s1, pd_s2;
  logic             dir, auto_on, sw_stb, sw_prime;
  logic [LEN_W-1:0] len, cnt;
  logic [NST-1:0]   en, pend, st_s1, st_s2, st_s3, match, ev;
  logic [2*NST-1:0] cond;
  stb_t             stb;

  wire wr_data = bus_wr && bus_addr == 3'd0;
  wire wr_ctrl = bus_wr && bus_addr == 3'd1;
  wire wr_len  = bus_wr && bus_addr == 3'd2;
  wire wr_en   = bus_wr && bus_addr == 3'd3;
  wire wr_pend = bus_wr && bus_addr == 3'd4;
  wire wr_clo  = bus_wr && bus_addr == 3'd6;
  wire wr_chi  = bus_wr && bus_addr == 3'd7;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0; dir <= 1'b0; auto_on <= 1'b0; sw_stb <= 1'b0; sw_prime <= 1'b0;
      len <= LEN_W'(LEN_RST); en <= '0; cond <= '0;
      pd_s1 <= '0; pd_s2 <= '0; st_s1 <= '0; st_s2 <= '0; st_s3 <= '0;
    end else begin
      if (wr_data) dout <= bus_wdata;
      if (wr_ctrl) {sw_prime, sw_stb, auto_on, dir} <= bus_wdata[3:0];
      if (wr_len)  len <= bus_wdata[LEN_W-1:0];
      if (wr_en)   en <= bus_wdata[NST-1:0];
      if (wr_clo)  cond[7:0] <= bus_wdata;
      if (wr_chi)  cond[9:8] <= bus_wdata[1:0];
      pd_s1 <= pd_in;  pd_s2 <= pd_s1;
      st_s1 <= st_in;  st_s2 <= st_s1;  st_s3 <= st_s2;
    end
  end

  for (genvar i = 0; i < NST; i++) begin : g_st
    logic [1:0] c;
    assign c        = cond[2*i +: 2];
    assign match[i] = c[0] ? ~st_s2[i] : st_s2[i];
    assign ev[i]    = c[0] ? (st_s2[i] & ~st_s3[i]) : (~st_s2[i] & st_s3[i]);

    always_ff @(posedge clk) begin
      if (!rst_n)    pend[i] <= 1'b0;
      else if (c[1]) pend[i] <= ev[i] | (pend[i] & ~(wr_pend & bus_wdata[i]));
      else           pend[i] <= en[i] & match[i];
    end

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pend && bus_wdata[i] && c[1] && !ev[i]) |=> !pend[i]); // R6
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !auto_on) begin
      stb <= S_IDLE; cnt <= '0;
    end else if (wr_data) begin
      stb <= S_SETUP; cnt <= SETUP_LAST;
    end else begin
      case (stb)
        S_SETUP: if (cnt == '0) begin
                   stb <= S_PULSE; cnt <= (len == '0) ? '0 : len - 1'b1;
                 end else cnt <= cnt - 1'b1;
        S_PULSE: if (cnt == '0) stb <= S_IDLE;
                 else cnt <= cnt - 1'b1;
        default: stb <= S_IDLE;
      endcase
    end
  end

  assign pd_out   = dout;
  assign pd_oe    = dir;
  assign strobe_n = ~((auto_on & (stb == S_PULSE)) | (~auto_on & sw_stb));
  assign prime_n  = ~sw_prime;
  assign irq      = |(pend & en);

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = dir ? dout : pd_s2;
      3'd1:    bus_rdata = {4'b0, sw_prime, sw_stb, auto_on, dir};
      3'd2:    bus_rdata = 8'(len);
      3'd3:    bus_rdata = {3'b0, en};
      3'd4:    bus_rdata = {3'b0, pend};
      3'd5:    bus_rdata = {3'b0, st_s2};
      3'd6:    bus_rdata = cond[7:0];
      default: bus_rdata = {6'b0, cond[9:8]};
    endcase
  end

  AST_AUTO_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && auto_on) |=> strobe_n); // R9
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (pd_oe == $past(bus_wdata[0]))); // R2
  AST_PRIME_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (prime_n == !$past(bus_wdata[3]))); // R11
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_wdata[4:0] == 5'd0) |=> !irq); // R8
  AST_AUTO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[1]) |=> (strobe_n == !$past(bus_wdata[2]))); // R12
endmodule

// File: tb/tb_lpt_port.sv
module tb_lpt_port;
  logic       clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, pd_in = '0;
  logic [4:0] st_in = '0;
  logic [7:0] bus_rdata, pd_out;
  logic       pd_oe, strobe_n, prime_n, irq;
  int tests = 0, fails = 0;
  string tag = "R1";

  lpt_port dut (.clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
                .pd_in, .pd_out, .pd_oe, .st_in, .strobe_n, .prime_n, .irq);

  always #2 clk = ~clk;

  // behavioural reference model
  logic [7:0] m_dout, m_len, m_p1, m_p2;
  logic       m_dir, m_auto, m_sws, m_swp;
  logic [4:0] m_en, m_pend, m_s1, m_s2, m_s3;
  logic [9:0] m_cond;
  int         m_setup, m_pulse;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dout = 0; m_len = 8'd4; m_p1 = 0; m_p2 = 0; m_dir = 0; m_auto = 0;
      m_sws = 0; m_swp = 0; m_en = 0; m_pend = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_cond = 0; m_setup = 0; m_pulse = 0;
    end else begin
      for (int i = 0; i < 5; i++) begin
        logic [1:0] c;
        logic ev;
        c = m_cond[2*i +: 2];
        if (c[1]) begin
          ev = c[0] ? (m_s2[i] && !m_s3[i]) : (!m_s2[i] && m_s3[i]);
          m_pend[i] = ev || (m_pend[i] && !(bus_wr && bus_addr == 4 && bus_wdata[i]));
        end else
          m_pend[i] = m_en[i] && (c[0] ? !m_s2[i] : m_s2[i]);
      end
      if (!m_auto) begin m_setup = 0; m_pulse = 0; end
      else if (bus_wr && bus_addr == 0) begin m_setup = 2; m_pulse = 0; end
      else if (m_setup > 0) begin
        m_setup--;
        if (m_setup == 0) m_pulse = (m_len == 0) ? 1 : m_len;
      end else if (m_pulse > 0) m_pulse--;
      if (bus_wr) case (bus_addr)
        0: m_dout = bus_wdata;
        1: {m_swp, m_sws, m_auto, m_dir} = bus_wdata[3:0];
        2: m_len = bus_wdata;
        3: m_en = bus_wdata[4:0];
        6: m_cond[7:0] = bus_wdata;
        7: m_cond[9:8] = bus_wdata[1:0];
        default: ;
      endcase
      m_p2 = m_p1; m_p1 = pd_in;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = st_in;
    end
  end

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      0: return m_dir ? m_dout : m_p2;
      1: return {4'b0, m_swp, m_sws, m_auto, m_dir};
      2: return m_len;
      3: return {3'b0, m_en};
      4: return {3'b0, m_pend};
      5: return {3'b0, m_s2};
      6: return m_cond[7:0];
      default: return {6'b0, m_cond[9:8]};
    endcase
  endfunction

  task automatic chk(string what, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("rdata", bus_rdata, exp_rd(bus_addr));
    chk("pd_out", pd_out, m_dout);
    chk("pd_oe", {7'b0, pd_oe}, {7'b0, m_dir});
    chk("strobe_n", {7'b0, strobe_n},
        {7'b0, m_auto ? !(m_setup == 0 && m_pulse > 0) : !m_sws});
    chk("prime_n", {7'b0, prime_n}, {7'b0, !m_swp});
    chk("irq", {7'b0, irq}, {7'b0, |(m_pend & m_en)});
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      bus_addr = 3'(k);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    tag = "R1";
    idle(8);
    tag = "R2";
    wr(1, 8'h01); wr(0, 8'hA5); idle(3); wr(0, 8'h3C); idle(2); wr(1, 8'h00); idle(2);
    tag = "R3";
    foreach (pd_in[b]) begin pd_in = 8'h1 << b; bus_addr = 0; @(posedge clk); #1; end
    pd_in = 8'hC3; idle(4); wr(1, 8'h01); bus_addr = 0; idle(2); wr(1, 8'h00);
    tag = "R4";
    st_in = 5'h15; idle(4); st_in = 5'h0A; bus_addr = 5; repeat (3) @(posedge clk); #1;
    tag = "R5";
    wr(6, 8'hE4); wr(7, 8'h02); idle(8); wr(6, 8'h1B); wr(7, 8'h01); idle(8);
    tag = "R6";
    wr(6, 8'hFF); wr(7, 8'h03); wr(3, 8'h1F); st_in = 0; idle(4);
    st_in = 5'h1F; idle(4); wr(4, 8'h05); idle(2); wr(4, 8'h1F); idle(2);
    st_in = 5'h01; @(posedge clk); #1; @(posedge clk); #1; wr(4, 8'h01); idle(3);
    wr(6, 8'hAA); wr(7, 8'h02); st_in = 5'h1F; idle(4);
    st_in = 5'h00; @(posedge clk); #1; @(posedge clk); #1; wr(4, 8'h1F); idle(3);
    wr(4, 8'h1F); idle(2);
    tag = "R7";
    wr(6, 8'h44); wr(7, 8'h01); st_in = 5'h03; idle(4); st_in = 5'h1C; idle(4);
    wr(3, 8'h00); idle(3); wr(3, 8'h1F); idle(3);
    tag = "R8";
    wr(3, 8'h01); idle(3); wr(3, 8'h10); idle(3); st_in = 5'h00; idle(4); wr(3, 8'h00); idle(2);
    tag = "R9";
    wr(1, 8'h03); wr(0, 8'h11); idle(8);
    wr(2, 8'h01); wr(0, 8'h22); idle(5);
    wr(2, 8'h00); wr(0, 8'h33); idle(5);
    wr(2, 8'h07); wr(0, 8'h44); idle(12);
    tag = "R10";
    wr(2, 8'h05); wr(0, 8'h55); idle(1); wr(0, 8'h66); idle(4); wr(0, 8'h77); idle(10);
    tag = "R11";
    wr(1, 8'h07); wr(0, 8'h88); idle(8); wr(1, 8'h0C); idle(3); wr(1, 8'h04); idle(2);
    wr(1, 8'h00); idle(2);
    tag = "R12";
    wr(1, 8'h02); wr(0, 8'h99); idle(3); wr(1, 8'h04); idle(3);
    wr(1, 8'h02); wr(0, 8'h9A); wr(1, 8'h00); idle(6);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule